// File: doc/BRIEF.md
# Hashed Page Table Walker

This block looks up one translation in a page table kept as a hash table in memory. A caller supplies a 24-bit segment identifier, a 32-bit effective address, the table base and the table mask, then pulses `start`. The walker forms a hash from the segment identifier and the page index and reads candidate entries over a word-read memory port. It searches a primary group of entries first and, if nothing matches there, a secondary group.

When an entry matches, the walker works out read, write and execute rights from the access key, the entry's 2-bit protection field and a no-execute input. It sets the entry's referenced and changed bits as the access requires. If either bit changed, it writes the entry's second word back. The walk ends with a one-cycle `done`, and the hit flag, real page number and rights are held until the next walk starts.

Each entry is two 32-bit words. Word 0 holds the valid bit (31), the segment identifier (30:7), the hash-select bit (6) and the abbreviated page index (5:0). Word 1 holds the real page number (31:12), the referenced bit (8), the changed bit (7) and the protection field (1:0).

Top module: `hpw_walker`

## Requirements
- R1: The page index is `eff_addr[27:12]` and the primary hash is `seg_id ^ {8'b0, page index}`. A group starts at `tbl_base + ((hash * 64) & tbl_mask)`. Entry i of a group sits at group start + 8*i, with word 0 at +0 and word 1 at +4.
- R2: A group's 8 entries are read in ascending order, and the first match ends the search. A hit at entry s of the primary group therefore costs exactly 2*(s+1) reads.
- R3: An entry matches only if word0[31] is 1, word0[6] equals the pass (0 for primary, 1 for secondary), word0[30:7] equals `seg_id`, and word0[5:0] equals `eff_addr[27:22]`.
- R4: If the primary group has no match, the secondary group at `tbl_base + ((~hash * 64) & tbl_mask)` is searched, using the 24-bit complement of the hash. A miss in both groups gives `hit`=0, `rpn`=0 and `perm`=0.
- R5: `perm` is {execute, write, read} in bits 2..0, with the protection field pp = word1[1:0]. With key 0, pp 0, 1 and 2 give read and write, and pp 3 gives read only. With key 1, pp 0 gives nothing, pp 1 and 3 give read only, and pp 2 gives read and write.
- R6: The execute bit of `perm` is the inverse of `no_exec` on every hit.
- R7: A hit on an entry whose referenced bit word1[8] is clear writes word 1 back with that bit set.
- R8: If the changed bit word1[7] is clear, a store whose write right is granted writes word 1 back with word1[7] set. Every other access to such an entry reports write permission 0. If word1[7] is already set, it is left unchanged.
- R9: Word 1 is written back, once, only when R7 or R8 set a bit. The written value is the old word 1 with those bits ORed in, and every other bit is unchanged.
- R10: On a hit, `rpn` equals word1[31:12] of the matching entry.
- R11: `mem_req` stays high, with `mem_addr` and `mem_we` stable, until `mem_ack`. Only one access is outstanding at a time.
- R12: `busy` rises the cycle after an accepted `start` and stays high through the single-cycle `done`. A `start` while `busy` is ignored.
- R13: After reset, `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| seg_id | input | 24 | Segment identifier |
| eff_addr | input | 32 | Effective address |
| tbl_base | input | 32 | Byte base address of the table |
| tbl_mask | input | 32 | Mask applied to the group offset |
| key | input | 1 | Access key |
| no_exec | input | 1 | Segment forbids execution |
| is_store | input | 1 | The access is a store (1) or a load (0) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| hit | output | 1 | A matching entry was found |
| rpn | output | 20 | Real page number |
| perm | output | 3 | Rights {execute, write, read} |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions check properties that must hold on every cycle:
- the memory request is held steady until it is acknowledged;
- `done` is a single pulse that comes inside `busy`;
- a miss reports empty results;
- a write right never appears without read;
- every write-back carries the referenced bit and follows a match.

Other behaviours can only be shown by the bench's scenarios, which sweep every combination of key, protection field, no-execute, access direction and the initial referenced and changed bits. These include:
- which entry wins and how many reads it costs;
- the exact rights value;
- the word left in memory;
- the secondary-group fallback with misleading hash-select bits.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  localparam int AW     = 32;
  localparam int VSID_W = 24;
  localparam int PIDX_W = 16;
  localparam int API_W  = 6;
  localparam int RPN_W  = 20;

  typedef enum logic [2:0] {
    S_IDLE, S_RD0, S_RD1, S_EVAL, S_WR, S_DONE
  } walk_st_e;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  function automatic logic [PIDX_W-1:0] page_index(input logic [AW-1:0] ea);
    return ea[27:12];
  endfunction

  function automatic logic [VSID_W-1:0] prim_hash(input logic [VSID_W-1:0] vsid,
                                                  input logic [PIDX_W-1:0] pidx);
    return vsid ^ {{(VSID_W-PIDX_W){1'b0}}, pidx};
  endfunction

  function automatic logic [VSID_W-1:0] pass_hash(input logic [VSID_W-1:0] h,
                                                  input logic second);
    return second ? ~h : h;
  endfunction

  function automatic perm_t base_rights(input logic k, input logic [1:0] pp,
                                        input logic nx);
    perm_t p;
    if (!k) begin
      p.r = 1'b1;
      p.w = (pp != 2'd3);
    end else begin
      p.r = (pp != 2'd0);
      p.w = (pp == 2'd2);
    end
    p.x = ~nx;
    return p;
  endfunction
endpackage

// File: rtl/hpw_addr_gen.sv
module hpw_addr_gen
  import hpw_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8
) (
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     mask,
  input  logic [VSID_W-1:0] hash,
  input  logic              second,
  input  logic [$clog2(GROUP_ENTRIES)-1:0] idx,
  input  logic              word_sel,
  output logic [AW-1:0]     addr
);
  localparam int IDX_W     = $clog2(GROUP_ENTRIES);
  localparam int ENT_SHIFT = 3;
  localparam int GRP_SHIFT = IDX_W + ENT_SHIFT;

  logic [VSID_W-1:0] h_sel;
  logic [AW-1:0]     grp_off;
  logic [AW-1:0]     ent_off;

  always_comb begin
    h_sel   = pass_hash(hash, second);
    grp_off = ({{(AW-VSID_W){1'b0}}, h_sel} << GRP_SHIFT) & mask;
    ent_off = AW'({idx, {ENT_SHIFT{1'b0}}});
    addr    = base + grp_off + ent_off + (word_sel ? AW'(4) : AW'(0));
  end
endmodule

// File: rtl/hpw_entry_match.sv
module hpw_entry_match
  import hpw_pkg::*;
(
  input  logic [31:0]       w0,
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  input  logic              second,
  output logic              match
);
  logic valid_ok, hsel_ok, tag_ok;

  always_comb begin
    valid_ok = w0[31];
    hsel_ok  = (w0[6] == second);
    tag_ok   = (w0[30:7] == vsid) && (w0[5:0] == api);
    match    = valid_ok && hsel_ok && tag_ok;
  end
endmodule

// File: rtl/hpw_rights_calc.sv
module hpw_rights_calc
  import hpw_pkg::*;
(
  input  logic        key,
  input  logic        nx,
  input  logic        store,
  input  logic [31:0] w1,
  output perm_t       perm_out,
  output logic [31:0] w1_new,
  output logic        need_wb
);
  perm_t base_p;
  logic  granted, ref_set, chg_set;

  always_comb begin
    base_p     = base_rights(key, w1[1:0], nx);
    granted    = store ? base_p.w : base_p.r;
    ref_set    = ~w1[8];
    chg_set    = ~w1[7] && store && granted;
    perm_out   = base_p;
    perm_out.w = base_p.w && (w1[7] || chg_set);
    w1_new     = w1 | {23'b0, ref_set, chg_set, 7'b0};
    need_wb    = ref_set || chg_set;
  end
endmodule

// File: rtl/hpw_walker.sv
module hpw_walker
  import hpw_pkg::*;
#(
  parameter int GROUP_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] seg_id,
  input  logic [31:0] eff_addr,
  input  logic [31:0] tbl_base,
  input  logic [31:0] tbl_mask,
  input  logic        key,
  input  logic        no_exec,
  input  logic        is_store,
  output logic        busy,
  output logic        done,
  output logic        hit,
  output logic [19:0] rpn,
  output logic [2:0]  perm,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  localparam int IDX_W = $clog2(GROUP_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

  walk_st_e          st;
  logic [VSID_W-1:0] vsid_q;
  logic [PIDX_W-1:0] pidx_q;
  logic [AW-1:0]     base_q, mask_q;
  logic              key_q, nx_q, store_q;
  logic              pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic [31:0]       w0_q, w1_q;
  logic              hit_q;
  logic [RPN_W-1:0]  rpn_q;
  perm_t             perm_q;

  logic [VSID_W-1:0] hash;
  logic              word_sel;
  logic              ent_match;
  perm_t             calc_perm;
  logic [31:0]       w1_new;
  logic              need_wb;

  // named events for the checker
  logic ev_match, ev_last, ev_accept;

  assign hash     = prim_hash(vsid_q, pidx_q);
  assign word_sel = (st == S_RD1) || (st == S_WR);

  hpw_addr_gen #(.GROUP_ENTRIES(GROUP_ENTRIES)) u_addr (
    .base(base_q), .mask(mask_q), .hash(hash), .second(pass_q),
    .idx(idx_q), .word_sel(word_sel), .addr(mem_addr)
  );

  hpw_entry_match u_match (
    .w0(w0_q), .vsid(vsid_q), .api(pidx_q[PIDX_W-1 -: API_W]),
    .second(pass_q), .match(ent_match)
  );

  hpw_rights_calc u_rights (
    .key(key_q), .nx(nx_q), .store(store_q), .w1(w1_q),
    .perm_out(calc_perm), .w1_new(w1_new), .need_wb(need_wb)
  );

  assign ev_match  = (st == S_EVAL) && ent_match;
  assign ev_last   = (idx_q == LAST_IDX);
  assign ev_accept = (st == S_IDLE) && start;

  assign mem_req   = (st == S_RD0) || (st == S_RD1) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_wdata = w1_new;
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign hit       = hit_q;
  assign rpn       = rpn_q;
  assign perm      = perm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vsid_q  <= '0;
      pidx_q  <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      key_q   <= 1'b0;
      nx_q    <= 1'b0;
      store_q <= 1'b0;
      pass_q  <= 1'b0;
      idx_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      hit_q   <= 1'b0;
      rpn_q   <= '0;
      perm_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (ev_accept) begin
          vsid_q  <= seg_id;
          pidx_q  <= page_index(eff_addr);
          base_q  <= tbl_base;
          mask_q  <= tbl_mask;
          key_q   <= key;
          nx_q    <= no_exec;
          store_q <= is_store;
          pass_q  <= 1'b0;
          idx_q   <= '0;
          hit_q   <= 1'b0;
          rpn_q   <= '0;
          perm_q  <= '0;
          st      <= S_RD0;
        end
        S_RD0: if (mem_ack) begin
          w0_q <= mem_rdata;
          st   <= S_RD1;
        end
        S_RD1: if (mem_ack) begin
          w1_q <= mem_rdata;
          st   <= S_EVAL;
        end
        S_EVAL: begin
          if (ev_match) begin
            hit_q  <= 1'b1;
            rpn_q  <= w1_q[31:12];
            perm_q <= calc_perm;
            st     <= need_wb ? S_WR : S_DONE;
          end else if (!ev_last) begin
            idx_q <= idx_q + 1'b1;
            st    <= S_RD0;
          end else if (!pass_q) begin
            pass_q <= 1'b1;
            idx_q  <= '0;
            st     <= S_RD0;
          end else begin
            st <= S_DONE;
          end
        end
        S_WR:   if (mem_ack) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpw_walker_chk.sv
module hpw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        hit,
  input logic [19:0] rpn,
  input logic [2:0]  perm,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        ev_match
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r12_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hit |-> (perm == 3'b000) && (rpn == 20'd0));

  a_r5_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    done && hit |-> (!perm[1] || perm[0]));

  a_r7_wb_sets_ref: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[8]);

  a_r9_wb_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(ev_match));

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done);
endmodule

bind hpw_walker hpw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .hit(hit), .rpn(rpn),
  .perm(perm), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .ev_match(ev_match)
);

// File: tb/hpw_walker_bench.sv
module hpw_walker_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_0400;
  localparam logic [31:0] MASK = 32'h0000_0FC0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] seg_id = '0;
  logic [31:0] eff_addr = '0;
  logic [31:0] tbl_base = BASE;
  logic [31:0] tbl_mask = MASK;
  logic        key = 1'b0, no_exec = 1'b0, is_store = 1'b0;
  logic        busy, done, hit;
  logic [19:0] rpn;
  logic [2:0]  perm;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:2047];
  int rd_cnt = 0, wr_cnt = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpw_walker u_hpw_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .seg_id(seg_id),
    .eff_addr(eff_addr), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
    .key(key), .no_exec(no_exec), .is_store(is_store), .busy(busy),
    .done(done), .hit(hit), .rpn(rpn), .perm(perm), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: ack one cycle after a request is seen
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[12:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[12:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] grp_addr(input logic [23:0] s, input logic [15:0] p,
                                           input bit sec);
    logic [23:0] h;
    h = s ^ {8'h00, p};
    if (sec) h = 24'hFFFFFF - h;
    return BASE + ((32'(h) * 64) & MASK);
  endfunction

  function automatic logic [31:0] mk_w0(input bit v, input logic [23:0] s,
                                        input bit h, input logic [5:0] a);
    return {v, s, h, a};
  endfunction

  task automatic put(input logic [31:0] g, input int slot, input logic [31:0] a,
                     input logic [31:0] b);
    mem[(g + 32'(slot * 8)) >> 2]     = a;
    mem[(g + 32'(slot * 8) + 4) >> 2] = b;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
  endtask

  // wrong-in-one-way filler for slot positions before a target
  function automatic logic [31:0] filler(input int kind, input logic [23:0] s,
                                         input logic [5:0] a, input bit pass);
    case (kind % 4)
      0: return mk_w0(1'b0, s, pass, a);
      1: return mk_w0(1'b1, s, ~pass, a);
      2: return mk_w0(1'b1, s ^ 24'h000100, pass, a);
      default: return mk_w0(1'b1, s, pass, a ^ 6'h01);
    endcase
  endfunction

  task automatic walk(input logic [23:0] s, input logic [31:0] ea, input bit k,
                      input bit nx, input bit stv, output int reads, output int writes);
    int r0, w0, n;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    seg_id = s; eff_addr = ea; key = k; no_exec = nx; is_store = stv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    if (!done) chk(1'b0, "R12 walk timeout", 32'(n), 32'd2000);
    reads = rd_cnt - r0; writes = wr_cnt - w0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rd, wr;
    clear_mem();
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!busy && !done && !mem_req, "R13 reset", {29'b0, busy, done, mem_req}, 32'h0);
    rst_n = 1'b1;

    // sweep of rights, bits and slot position: R1 R2 R3 R5 R6 R7 R8 R9 R10
    for (int c = 0; c < 128; c++) begin
      bit k, nx, stv, rb, cb, r, w, gr, chg, wx;
      logic [1:0] pp;
      logic [23:0] s;
      logic [15:0] p;
      logic [19:0] pg;
      logic [31:0] g, w1, w1e;
      int slot;
      k = c[0]; pp = c[2:1]; nx = c[3]; stv = c[4]; rb = c[5]; cb = c[6];
      s = 24'h0A5000 + 24'(c * 37);
      p = 16'(c * 517);
      pg = 20'(c * 4099 + 1);
      slot = c % 8;
      clear_mem();
      g = grp_addr(s, p, 1'b0);
      for (int f = 0; f < slot; f++) put(g, f, filler(f + c, s, p[15:10], 1'b0), 32'hFFFF_F1A3);
      w1 = {pg, 3'b000, rb, cb, 5'b00000, pp};
      put(g, slot, mk_w0(1'b1, s, 1'b0, p[15:10]), w1);
      walk(s, {4'h7, p, 12'hABC}, k, nx, stv, rd, wr);
      r  = k ? (pp != 2'd0) : 1'b1;
      w  = k ? (pp == 2'd2) : (pp != 2'd3);
      gr = stv ? w : r;
      chg = !cb && stv && gr;
      wx = w && (cb || chg);
      w1e = w1 | (rb ? 32'h0 : 32'h100) | (chg ? 32'h80 : 32'h0);
      chk(hit == 1'b1, "R3 hit", 32'(hit), 32'd1);
      chk(rpn == pg, "R10 rpn", 32'(rpn), 32'(pg));
      chk(perm == {!nx, wx, r}, "R5 R6 R8 perm", 32'(perm), 32'({!nx, wx, r}));
      chk(rd == 2 * (slot + 1), "R2 R1 reads", 32'(rd), 32'(2 * (slot + 1)));
      chk(wr == ((!rb || chg) ? 1 : 0), "R9 writes", 32'(wr), 32'((!rb || chg) ? 1 : 0));
      chk(mem[(g + 32'(slot * 8) + 4) >> 2] == w1e, "R7 R8 word1",
          mem[(g + 32'(slot * 8) + 4) >> 2], w1e);
    end

    // secondary group: R4 R3
    for (int sl = 0; sl < 8; sl++) begin
      logic [23:0] s;
      logic [15:0] p;
      logic [31:0] gp, gs;
      s = 24'h3C0000 + 24'(sl * 1111);
      p = 16'hB000 + 16'(sl * 77);
      clear_mem();
      gp = grp_addr(s, p, 1'b0);
      gs = grp_addr(s, p, 1'b1);
      for (int f = 0; f < 8; f++) put(gp, f, mk_w0(1'b1, s, 1'b1, p[15:10]), 32'h1111_1003);
      for (int f = 0; f < sl; f++) put(gs, f, mk_w0(1'b1, s, 1'b0, p[15:10]), 32'h2222_2003);
      put(gs, sl, mk_w0(1'b1, s, 1'b1, p[15:10]), {20'h5A5A0 + 20'(sl), 12'h180});
      walk(s, {4'h1, p, 12'h000}, 1'b0, 1'b0, 1'b0, rd, wr);
      chk(hit == 1'b1, "R4 secondary hit", 32'(hit), 32'd1);
      chk(rpn == 20'h5A5A0 + 20'(sl), "R4 secondary rpn", 32'(rpn), 32'(20'h5A5A0 + 20'(sl)));
      chk(rd == 16 + 2 * (sl + 1), "R4 secondary reads", 32'(rd), 32'(16 + 2 * (sl + 1)));
      chk(wr == 0, "R9 no write", 32'(wr), 32'd0);
    end

    // full miss: R4
    begin
      logic [23:0] s;
      logic [15:0] p;
      s = 24'h777777; p = 16'h1234;
      clear_mem();
      for (int f = 0; f < 8; f++) begin
        put(grp_addr(s, p, 1'b0), f, filler(f, s, p[15:10], 1'b0), 32'hFFFF_F003);
        put(grp_addr(s, p, 1'b1), f, filler(f, s, p[15:10], 1'b1), 32'hFFFF_F003);
      end
      walk(s, {4'h0, p, 12'h000}, 1'b0, 1'b0, 1'b1, rd, wr);
      chk(hit == 1'b0, "R4 miss hit", 32'(hit), 32'd0);
      chk(rpn == 20'd0 && perm == 3'd0, "R4 miss outputs", {9'b0, perm, rpn}, 32'h0);
      chk(rd == 32, "R4 miss reads", 32'(rd), 32'd32);
      chk(wr == 0, "R9 miss no write", 32'(wr), 32'd0);
    end

    // first match wins: R2
    begin
      logic [23:0] s;
      logic [15:0] p;
      logic [31:0] g;
      s = 24'h010203; p = 16'h4321;
      clear_mem();
      g = grp_addr(s, p, 1'b0);
      put(g, 2, mk_w0(1'b1, s, 1'b0, p[15:10]), 32'hAAAA_A180);
      put(g, 5, mk_w0(1'b1, s, 1'b0, p[15:10]), 32'hBBBB_B180);
      walk(s, {4'h0, p, 12'h000}, 1'b0, 1'b0, 1'b0, rd, wr);
      chk(rpn == 20'hAAAAA, "R2 first match rpn", 32'(rpn), 32'hAAAAA);
      chk(rd == 6, "R2 first match reads", 32'(rd), 32'd6);
    end

    // start while busy is ignored: R12
    begin
      logic [23:0] s;
      logic [15:0] p;
      int n;
      s = 24'h00ABCD; p = 16'h0F0F;
      clear_mem();
      put(grp_addr(s, p, 1'b0), 3, mk_w0(1'b1, s, 1'b0, p[15:10]), 32'hC0DE_1182);
      @(negedge clk);
      seg_id = s; eff_addr = {4'h0, p, 12'h0}; key = 1'b1; no_exec = 1'b1;
      is_store = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R12 busy after start", 32'(busy), 32'd1);
      @(negedge clk);
      seg_id = 24'hFFFFFF; eff_addr = 32'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      chk(done && busy, "R12 done with busy", {30'b0, done, busy}, 32'h3);
      chk(hit && rpn == 20'hC0DE1, "R12 second start ignored", 32'(rpn), 32'hC0DE1);
      chk(perm == 3'b011, "R12 perm of first walk", 32'(perm), 32'h3);
      @(negedge clk);
      chk(!done && !busy, "R12 done single cycle", {30'b0, done, busy}, 32'h0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule